// File: doc/BRIEF.md
# Zero-Crossing Timing Feedback Controller

This block closes the digital timing loop of a boost converter running in pulse-frequency modulation with discontinuous conduction. Each time the high-side switch opens, the controller waits a fixed number of clock cycles. It then registers the logic level of the switch node once. A high level means current was still flowing when the switch opened, so the switch opened early. A low level means the current had already reached zero, so the switch opened late.

That single bit drives a saturating up/down counter. The counter is the loop integrator, and its value is the control word of the pulse generator. A larger word gives a shorter oscillator period and a shorter low-side on-time, so the peak current and the high-side conduction time both shrink. In steady state the word alternates between two neighbouring values.

When the word sits at zero, the input source is taken to be critically low. A load-disconnect output is then raised so the input can recover. All ports are plain control and status pins with no valid/ready handshake. The turn-off event is a level sampled on each clock edge, and the block has no back-pressure.

Top module: `zc_timing_ctrl`

## Requirements
- R1: After reset the control word is mid-scale, 8 for the default 4-bit width, and `load_off` is low.
- R2: The switch-node level is taken only at the rising clock edge that comes exactly `SAMPLE_DELAY` edges after the edge at which `hs_off` is seen high. With the default of 3, a level that holds the opposite value at every other edge has no effect.
- R3: A sampled high level raises the control word by exactly one.
- R4: A sampled low level lowers the control word by exactly one.
- R5: An `hs_off` seen high while a sample is still pending is ignored, so each accepted turn-off event moves the word by at most one step.
- R6: At the top value (15) a high sample leaves the word at 15. It does not wrap.
- R7: At zero a low sample leaves the word at 0. It does not wrap.
- R8: `load_off` is high exactly when the control word is zero, and it drops in the same cycle the word leaves zero.
- R9: The word changes only at the edge after the sampling edge, which is `SAMPLE_DELAY`+1 edges after `hs_off` is seen. It holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_off | input | 1 | High for a cycle when the high-side switch opens |
| sw_level | input | 1 | Logic level of the switch node |
| ctrl_word | output | 4 | Control word of the pulse generator |
| load_off | output | 1 | Load disconnect request, high while the word is zero |

## Verification
The assertions rely on `hs_off` being a synchronous level that the bench changes only away from the active edge. They also assume that `sw_level` matters only at the sampling edge. Beyond that, they assume only that the counter never moves without a sample strobe. The bench drives every input at the falling edge. It holds `sw_level` at the opposite value except across the one sampling edge. It places repeated turn-off pulses only inside the pending window or after the word has settled, so each event's expected step is known in advance.

// File: rtl/zc_pkg.sv
package zc_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } step_dir_e;
endpackage

// File: rtl/zc_sampler.sv
module zc_sampler #(
  parameter int SAMPLE_DELAY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_off,
  input  logic sw_level,
  output logic smp_vld,
  output logic smp_bit
);
  localparam int DLY_W = (SAMPLE_DELAY > 1) ? $clog2(SAMPLE_DELAY) : 1;
  localparam logic [DLY_W-1:0] LAST = DLY_W'(SAMPLE_DELAY - 1);

  logic             pending;
  logic [DLY_W-1:0] wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      wait_cnt <= '0;
      smp_vld  <= 1'b0;
      smp_bit  <= 1'b0;
    end else begin
      smp_vld <= 1'b0;
      if (pending) begin
        if (wait_cnt == LAST) begin
          pending <= 1'b0;
          smp_vld <= 1'b1;
          smp_bit <= sw_level;
        end else begin
          wait_cnt <= wait_cnt + 1'b1;
        end
      end else if (hs_off) begin
        pending  <= 1'b1;
        wait_cnt <= '0;
      end
    end
  end

  // Two strobes are always at least two cycles apart.
  AST_ONE_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> !smp_vld); // R5
endmodule

// File: rtl/zc_integrator.sv
module zc_integrator
  import zc_pkg::*;
#(
  parameter int CTRL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  step_dir_e         step_dir,
  output logic [CTRL_W-1:0] word
);
  localparam logic [CTRL_W-1:0] TOP = {CTRL_W{1'b1}};
  localparam logic [CTRL_W-1:0] MID = CTRL_W'(1) << (CTRL_W - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= MID;
    end else if (step_en) begin
      if (step_dir == DIR_UP && word != TOP)
        word <= word + 1'b1;
      else if (step_dir == DIR_DOWN && word != '0)
        word <= word - 1'b1;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(word)); // R9
  AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && step_dir == DIR_UP && word == TOP) |=> word == TOP); // R6
  AST_SAT_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && step_dir == DIR_DOWN && word == '0) |=> word == '0); // R7
  AST_UNIT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && step_dir == DIR_UP && word != TOP) |=> word == $past(word) + 1'b1); // R3
  AST_UNIT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && step_dir == DIR_DOWN && word != '0) |=> word == $past(word) - 1'b1); // R4
endmodule

// File: rtl/zc_zero_detect.sv
module zc_zero_detect #(
  parameter int CTRL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] word,
  output logic              load_off
);
  assign load_off = (word == '0);

  AST_LOAD_OFF_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_off) |-> $past(word) == CTRL_W'(1)); // R8
  AST_LOAD_OFF_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load_off) |-> word == CTRL_W'(1)); // R8
endmodule

// File: rtl/zc_timing_ctrl.sv
module zc_timing_ctrl
  import zc_pkg::*;
#(
  parameter int CTRL_W       = 4,
  parameter int SAMPLE_DELAY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_off,
  input  logic              sw_level,
  output logic [CTRL_W-1:0] ctrl_word,
  output logic              load_off
);
  logic      smp_vld;
  logic      smp_bit;
  step_dir_e dir;

  assign dir = smp_bit ? DIR_UP : DIR_DOWN;

  zc_sampler #(.SAMPLE_DELAY(SAMPLE_DELAY)) u_sampler (
    .clk(clk), .rst_n(rst_n), .hs_off(hs_off), .sw_level(sw_level),
    .smp_vld(smp_vld), .smp_bit(smp_bit)
  );

  zc_integrator #(.CTRL_W(CTRL_W)) u_integ (
    .clk(clk), .rst_n(rst_n), .step_en(smp_vld), .step_dir(dir),
    .word(ctrl_word)
  );

  zc_zero_detect #(.CTRL_W(CTRL_W)) u_zero (
    .clk(clk), .rst_n(rst_n), .word(ctrl_word), .load_off(load_off)
  );

  AST_RESET_MID: assert property (@(posedge clk)
    $rose(rst_n) |-> ctrl_word == (CTRL_W'(1) << (CTRL_W - 1)) && !load_off); // R1
endmodule

// File: tb/test_zc_timing_ctrl.sv
module test_zc_timing_ctrl;
  localparam int W   = 4;
  localparam int DLY = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         hs_off = 1'b0;
  logic         sw_level = 1'b0;
  logic [W-1:0] ctrl_word;
  logic         load_off;

  int n_chk = 0;
  int n_bad = 0;
  int model = 8;
  bit done = 0;

  always #5 clk = ~clk;

  zc_timing_ctrl #(.CTRL_W(W), .SAMPLE_DELAY(DLY)) i_zc_timing_ctrl (
    .clk(clk), .rst_n(rst_n), .hs_off(hs_off), .sw_level(sw_level),
    .ctrl_word(ctrl_word), .load_off(load_off)
  );

  function automatic int next_word(int cur, bit hi);
    if (hi) return (cur == 15) ? 15 : cur + 1;
    return (cur == 0) ? 0 : cur - 1;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_state(string req);
    check(req, int'(ctrl_word), model);
    check({req, "/R8"}, int'(load_off), (model == 0) ? 1 : 0);
  endtask

  // One switching event: sw_level carries 'hi' only across the sampling edge.
  task automatic event_cycle(bit hi, int extra_hold, string req);
    @(negedge clk);
    hs_off = 1'b1;
    sw_level = ~hi;
    @(negedge clk);                 // after edge k
    if (extra_hold == 0) hs_off = 1'b0;
    for (int i = 0; i < DLY - 1; i++) begin
      @(negedge clk);
      hs_off = 1'b0;
      if (i == 0) begin
        // R9: nothing moves before the sample is taken
        check("R9", int'(ctrl_word), model);
      end
    end
    sw_level = hi;
    @(negedge clk);                 // after edge k+DLY (sampling edge)
    sw_level = ~hi;
    check("R9", int'(ctrl_word), model);
    @(negedge clk);                 // after edge k+DLY+1
    model = next_word(model, hi);
    check_state(req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1");

    event_cycle(1'b1, 0, "R2/R3");
    event_cycle(1'b0, 0, "R2/R4");

    // R5: hs_off held for two cycles, the second one is ignored.
    event_cycle(1'b1, 1, "R5");
    repeat (DLY + 2) @(negedge clk);
    check("R5", int'(ctrl_word), model);

    // R7 and R8: drive down to zero and beyond.
    for (int i = 0; i < 12; i++) event_cycle(1'b0, 0, "R4/R7");
    check("R7", int'(ctrl_word), 0);
    check("R8", int'(load_off), 1);
    event_cycle(1'b1, 0, "R8");
    check("R8", int'(load_off), 0);

    // R6: drive to the top and beyond.
    for (int i = 0; i < 18; i++) event_cycle(1'b1, 0, "R3/R6");
    check("R6", int'(ctrl_word), 15);

    // Dither between adjacent values.
    for (int i = 0; i < 6; i++) event_cycle(i[0], 0, "R3/R4");

    // Constrained random sequence with a fixed seed.
    void'($urandom(32'd1234));
    for (int i = 0; i < 150; i++) begin
      int gap;
      event_cycle(1'($urandom_range(1, 0)), int'($urandom_range(1, 0)), "R2/R3/R4/R5");
      gap = int'($urandom_range(3, 0));
      repeat (gap) @(negedge clk);
      check("R9", int'(ctrl_word), model);
    end

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule